// File: doc/BRIEF.md
# Saturating Dual 40-bit Accumulator Unit

This block holds two 40-bit signed accumulators, called A and B, that share one 41-bit adder/subtracter. Each operation picks one accumulator as its destination. The operation either adds a 40-bit operand to that accumulator, subtracts the operand from it, or loads the operand directly. For a load, the accumulator side of the adder is forced to zero. The operand is usually a product that arrives from a multiplier. Each accumulator value is a 1.31 fraction held in bits 31..0, with eight guard bits (39..32) above it.

The adder result passes through a saturation stage before it is written back. Each accumulator has its own saturation enable. One shared mode input chooses where the clamp applies:
- Normal mode clamps at the edge of the 1.31 range.
- Extended mode clamps at the edge of the full 40-bit range.

Each accumulator has two flags:
- A guard-overflow flag, recomputed on every operation that writes the accumulator.
- A sticky saturation flag. It records either a clamp or an overflow out of bit 39 that destroyed the sign.

Two summary outputs OR the flags of both accumulators. A trap request is raised when an enabled accumulator shows a guard overflow.

Top module: `dual_acc_unit`

## Requirements
- R1: An operation with opValid=1 and opCode=2'b00 (add) writes acc+operand into the accumulator chosen by accSel (0 selects A, 1 selects B) on the next rising clock edge. The value is two's complement, 40 bits.
- R2: opCode=2'b01 (subtract) writes acc-operand into the selected accumulator.
- R3: opCode=2'b10 (load) forces the accumulator input of the adder to zero, so the operand itself is written (then subject to saturation).
- R4: On each operation, the destination's guard-overflow flag is set if bits 40..31 of the exact 41-bit result are not all equal, and cleared otherwise. The flag is recomputed even when the result is clamped.
- R5: With saturation disabled, the low 40 bits of the result are written unchanged. If bits 40 and 39 of the exact result differ (sign lost), the destination's saturation flag is set.
- R6: With saturation enabled and satModeExt=0, a result that sets the guard-overflow flag is clamped. A positive result becomes 0x007FFFFFFF and a negative one becomes 0xFF80000000. The saturation flag is set.
- R7: With saturation enabled and satModeExt=1, only a result whose bits 40 and 39 differ is clamped, to 0x7FFFFFFFFF (positive) or 0x8000000000 (negative). This also sets the saturation flag. Otherwise the low 40 bits are written.
- R8: A saturation flag stays set until flagClear=1 clears both flags. If a saturation event and flagClear occur in the same cycle, the flag of that event's destination is set.
- R9: ovfAny is ovfA OR ovfB, and satAny is satA OR satB.
- R10: trapReq is high exactly while (ovfA and trapEnA) or (ovfB and trapEnB).
- R11: The unselected accumulator and its flags keep their values. With opValid=0, or with opCode=2'b11 (no operation), neither accumulator and neither guard flag changes.
- R12: After reset, both accumulators and all flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation strobe |
| opCode | input | 2 | 00 add, 01 subtract, 10 load, 11 none |
| accSel | input | 1 | Destination: 0 = A, 1 = B |
| operand | input | 40 | Signed operand |
| satEnA | input | 1 | Saturation enable for A |
| satEnB | input | 1 | Saturation enable for B |
| satModeExt | input | 1 | 0 = clamp at 1.31 range, 1 = clamp at 40-bit range |
| trapEnA | input | 1 | Trap enable for A guard overflow |
| trapEnB | input | 1 | Trap enable for B guard overflow |
| flagClear | input | 1 | Clears both saturation flags |
| accA | output | 40 | Accumulator A |
| accB | output | 40 | Accumulator B |
| ovfA | output | 1 | A guard-overflow flag |
| ovfB | output | 1 | B guard-overflow flag |
| satA | output | 1 | A sticky saturation flag |
| satB | output | 1 | B sticky saturation flag |
| ovfAny | output | 1 | ovfA OR ovfB |
| satAny | output | 1 | satA OR satB |
| trapReq | output | 1 | Arithmetic trap request |

## Verification
The hardest case to reach from the ports is a loss of sign out of bit 39. It needs an accumulator sitting at the very edge of the 40-bit range, and such a value can only be built up through operations. The stimulus first loads 0x7FFFFFFFFF or 0x8000000000 with saturation off, then steps one count past the edge. It does this three ways: unsaturated (wrap plus sticky flag), in extended mode (clamp), and in normal mode on other vectors. A saturation flag is cleared before each vector so that every vector's flag reflects only that vector. Directed steps then check that the flag is sticky, that a saturation event wins over a same-cycle clear, and that the unselected accumulator holds.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  localparam int NUM_ACC = 2;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_LOAD = 2'b10,
    OP_NONE = 2'b11
  } op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_ACC-1:0] wrEn;     // one-hot destination, zero when idle
    logic               zeroAcc;  // force accumulator side of adder to zero
    logic               invertOp; // complement operand
    logic               carryIn;  // adder carry input
    logic [NUM_ACC-1:0] satEn;    // per-accumulator saturation enable
    logic               satExt;   // clamp at full width instead of 1.31
    logic               clearSat; // clear sticky saturation flags
  } ctrl_t;
endpackage

// File: rtl/dacc_ctrl.sv
module dacc_ctrl
  import dacc_pkg::*;
(
  input  logic        opValid,
  input  logic [1:0]  opCode,
  input  logic        accSel,
  input  logic        satEnA,
  input  logic        satEnB,
  input  logic        satModeExt,
  input  logic        flagClear,
  output ctrl_t       strobes
);
  op_e opKind;
  logic doWrite;

  assign opKind  = op_e'(opCode);
  assign doWrite = opValid && (opKind != OP_NONE);

  always_comb begin
    strobes          = '0;
    strobes.satEn    = {satEnB, satEnA};
    strobes.satExt   = satModeExt;
    strobes.clearSat = flagClear;
    if (doWrite) begin
      for (int i = 0; i < NUM_ACC; i++) begin
        strobes.wrEn[i] = (accSel == i[0]);
      end
    end
    case (opKind)
      OP_ADD: begin
        strobes.invertOp = 1'b0;
        strobes.carryIn  = 1'b0;
      end
      OP_SUB: begin
        strobes.invertOp = 1'b1;
        strobes.carryIn  = 1'b1;
      end
      OP_LOAD: begin
        strobes.zeroAcc  = 1'b1;
      end
      default: begin
        strobes.wrEn     = '0;
      end
    endcase
  end
endmodule

// File: rtl/dacc_sat.sv
module dacc_sat #(
  parameter int ACC_W = 40,
  parameter int VAL_W = 32
) (
  input  logic [ACC_W:0]   trueSum,
  input  logic             satEn,
  input  logic             satExt,
  output logic [ACC_W-1:0] result,
  output logic             guardOvf,
  output logic             satEvent
);
  localparam int HEAD_W = ACC_W - VAL_W + 2;  // bits ACC_W down to VAL_W-1
  localparam logic [ACC_W-1:0] NORM_MAX = {{(ACC_W-VAL_W+1){1'b0}}, {(VAL_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NORM_MIN = ~NORM_MAX;
  localparam logic [ACC_W-1:0] EXT_MAX  = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] EXT_MIN  = ~EXT_MAX;

  logic [HEAD_W-1:0] head;
  logic signLost;
  logic isNeg;
  logic clamp;

  assign head     = trueSum[ACC_W:VAL_W-1];
  assign guardOvf = !((&head) || !(|head));
  assign signLost = trueSum[ACC_W] ^ trueSum[ACC_W-1];
  assign isNeg    = trueSum[ACC_W];

  always_comb begin
    result = trueSum[ACC_W-1:0];
    clamp  = 1'b0;
    if (satEn) begin
      if (!satExt && guardOvf) begin
        result = isNeg ? NORM_MIN : NORM_MAX;
        clamp  = 1'b1;
      end else if (satExt && signLost) begin
        result = isNeg ? EXT_MIN : EXT_MAX;
        clamp  = 1'b1;
      end
    end
  end

  assign satEvent = clamp || signLost;
endmodule

// File: rtl/dacc_datapath.sv
module dacc_datapath
  import dacc_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int VAL_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrl_t                           strobes,
  input  logic [ACC_W-1:0]                operand,
  output logic [NUM_ACC-1:0][ACC_W-1:0]   accOut,
  output logic [NUM_ACC-1:0]              ovfOut,
  output logic [NUM_ACC-1:0]              satOut
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] srcAcc;
  logic [SUM_W-1:0] addA, addB, opExt, trueSum;
  logic             destSatEn;
  logic [ACC_W-1:0] wrValue;
  logic             guardOvf, satEvent;

  always_comb begin
    srcAcc = '0;
    for (int i = 0; i < NUM_ACC; i++) begin
      if (strobes.wrEn[i]) srcAcc = srcAcc | accOut[i];
    end
  end

  assign opExt     = {operand[ACC_W-1], operand};
  assign addA      = strobes.zeroAcc ? '0 : {srcAcc[ACC_W-1], srcAcc};
  assign addB      = strobes.invertOp ? ~opExt : opExt;
  assign trueSum   = addA + addB + SUM_W'(strobes.carryIn);
  assign destSatEn = |(strobes.satEn & strobes.wrEn);

  dacc_sat #(.ACC_W(ACC_W), .VAL_W(VAL_W)) sat_i (
    .trueSum  (trueSum),
    .satEn    (destSatEn),
    .satExt   (strobes.satExt),
    .result   (wrValue),
    .guardOvf (guardOvf),
    .satEvent (satEvent)
  );

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accOut[g] <= '0;
        ovfOut[g] <= 1'b0;
        satOut[g] <= 1'b0;
      end else begin
        if (strobes.wrEn[g]) begin
          accOut[g] <= wrValue;
          ovfOut[g] <= guardOvf;
        end
        if (strobes.wrEn[g] && satEvent) begin
          satOut[g] <= 1'b1;
        end else if (strobes.clearSat) begin
          satOut[g] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dual_acc_unit.sv
module dual_acc_unit
  import dacc_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int VAL_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       opCode,
  input  logic             accSel,
  input  logic [ACC_W-1:0] operand,
  input  logic             satEnA,
  input  logic             satEnB,
  input  logic             satModeExt,
  input  logic             trapEnA,
  input  logic             trapEnB,
  input  logic             flagClear,
  output logic [ACC_W-1:0] accA,
  output logic [ACC_W-1:0] accB,
  output logic             ovfA,
  output logic             ovfB,
  output logic             satA,
  output logic             satB,
  output logic             ovfAny,
  output logic             satAny,
  output logic             trapReq
);
  ctrl_t                          strobes;
  logic [NUM_ACC-1:0][ACC_W-1:0]  accVec;
  logic [NUM_ACC-1:0]             ovfVec, satVec;

  dacc_ctrl ctrl_i (
    .opValid    (opValid),
    .opCode     (opCode),
    .accSel     (accSel),
    .satEnA     (satEnA),
    .satEnB     (satEnB),
    .satModeExt (satModeExt),
    .flagClear  (flagClear),
    .strobes    (strobes)
  );

  dacc_datapath #(.ACC_W(ACC_W), .VAL_W(VAL_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .operand (operand),
    .accOut  (accVec),
    .ovfOut  (ovfVec),
    .satOut  (satVec)
  );

  assign accA    = accVec[0];
  assign accB    = accVec[1];
  assign ovfA    = ovfVec[0];
  assign ovfB    = ovfVec[1];
  assign satA    = satVec[0];
  assign satB    = satVec[1];
  assign ovfAny  = |ovfVec;
  assign satAny  = |satVec;
  assign trapReq = |(ovfVec & {trapEnB, trapEnA});
endmodule

// File: rtl/dacc_checker.sv
module dacc_checker #(
  parameter int ACC_W = 40,
  parameter int VAL_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [1:0]       opCode,
  input logic             accSel,
  input logic [ACC_W-1:0] operand,
  input logic             satEnA,
  input logic             satModeExt,
  input logic             flagClear,
  input logic [ACC_W-1:0] accA,
  input logic [ACC_W-1:0] accB,
  input logic             ovfB,
  input logic             satA,
  input logic             satB
);
  logic writeA, writeB;
  assign writeA = opValid && (opCode != 2'b11) && !accSel;
  assign writeB = opValid && (opCode != 2'b11) && accSel;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!writeA && !writeB) |=> ($stable(accA) && $stable(accB))); // R11

  AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    writeA |=> ($stable(accB) && $stable(ovfB))); // R11

  AST_LOAD_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (writeA && opCode == 2'b10 && !satEnA) |=> (accA == $past(operand))); // R3

  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (satA && !flagClear) |=> satA); // R8

  AST_SAT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !opValid) |=> (!satA && !satB)); // R8

  AST_NORM_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (writeA && satEnA && !satModeExt) |=>
      ((&accA[ACC_W-1:VAL_W-1]) || !(|accA[ACC_W-1:VAL_W-1]))); // R6
endmodule

bind dual_acc_unit dacc_checker #(.ACC_W(ACC_W), .VAL_W(VAL_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .opValid    (opValid),
  .opCode     (opCode),
  .accSel     (accSel),
  .operand    (operand),
  .satEnA     (satEnA),
  .satModeExt (satModeExt),
  .flagClear  (flagClear),
  .accA       (accA),
  .accB       (accB),
  .ovfB       (ovfB),
  .satA       (satA),
  .satB       (satB)
);

// File: tb/dual_acc_unit_tb_top.sv
`timescale 1ns/1ps
module dual_acc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = 2'b11;
  logic        accSel = 1'b0;
  logic [39:0] operand = '0;
  logic        satEnA = 1'b0, satEnB = 1'b0, satModeExt = 1'b0;
  logic        trapEnA = 1'b0, trapEnB = 1'b0, flagClear = 1'b0;
  logic [39:0] accA, accB;
  logic        ovfA, ovfB, satA, satB, ovfAny, satAny, trapReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_acc_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .accSel(accSel),
    .operand(operand), .satEnA(satEnA), .satEnB(satEnB), .satModeExt(satModeExt),
    .trapEnA(trapEnA), .trapEnB(trapEnB), .flagClear(flagClear),
    .accA(accA), .accB(accB), .ovfA(ovfA), .ovfB(ovfB), .satA(satA), .satB(satB),
    .ovfAny(ovfAny), .satAny(satAny), .trapReq(trapReq)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        sel;
    logic        sen;
    logic        ext;
    logic [39:0] opnd;
    logic [39:0] expAcc;
    logic        expOvf;
    logic        expSat;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 1'b0, 1'b0, 1'b0, 40'h0000001234, 40'h0000001234, 1'b0, 1'b0},
    '{2'b00, 1'b0, 1'b0, 1'b0, 40'h0000000010, 40'h0000001244, 1'b0, 1'b0},
    '{2'b01, 1'b0, 1'b0, 1'b0, 40'h0000001300, 40'hFFFFFFFF44, 1'b0, 1'b0},
    '{2'b10, 1'b0, 1'b0, 1'b0, 40'h007FFFFFFF, 40'h007FFFFFFF, 1'b0, 1'b0},
    '{2'b00, 1'b0, 1'b0, 1'b0, 40'h0000000001, 40'h0080000000, 1'b1, 1'b0},
    '{2'b10, 1'b0, 1'b0, 1'b0, 40'h007FFFFFFF, 40'h007FFFFFFF, 1'b0, 1'b0},
    '{2'b00, 1'b0, 1'b1, 1'b0, 40'h0000000001, 40'h007FFFFFFF, 1'b1, 1'b1},
    '{2'b10, 1'b0, 1'b0, 1'b0, 40'hFF80000000, 40'hFF80000000, 1'b0, 1'b0},
    '{2'b01, 1'b0, 1'b1, 1'b0, 40'h0000000001, 40'hFF80000000, 1'b1, 1'b1},
    '{2'b10, 1'b0, 1'b0, 1'b0, 40'h7FFFFFFFFF, 40'h7FFFFFFFFF, 1'b1, 1'b0},
    '{2'b00, 1'b0, 1'b0, 1'b0, 40'h0000000001, 40'h8000000000, 1'b1, 1'b1},
    '{2'b10, 1'b0, 1'b0, 1'b0, 40'h7FFFFFFFFF, 40'h7FFFFFFFFF, 1'b1, 1'b0},
    '{2'b00, 1'b0, 1'b1, 1'b1, 40'h0000000001, 40'h7FFFFFFFFF, 1'b1, 1'b1},
    '{2'b10, 1'b0, 1'b0, 1'b0, 40'h8000000000, 40'h8000000000, 1'b1, 1'b0},
    '{2'b01, 1'b0, 1'b1, 1'b1, 40'h0000000001, 40'h8000000000, 1'b1, 1'b1},
    '{2'b10, 1'b0, 1'b1, 1'b1, 40'h0100000000, 40'h0100000000, 1'b1, 1'b0},
    '{2'b10, 1'b1, 1'b0, 1'b0, 40'h0000000055, 40'h0000000055, 1'b0, 1'b0},
    '{2'b01, 1'b1, 1'b0, 1'b0, 40'h0000000055, 40'h0000000000, 1'b0, 1'b0},
    '{2'b10, 1'b1, 1'b1, 1'b0, 40'h0100000000, 40'h007FFFFFFF, 1'b1, 1'b1}
  };

  function automatic string vecReq(int i);
    case (i)
      1:              return "R1";
      2, 17:          return "R2";
      4, 9, 13, 15:   return "R4";
      10:             return "R5";
      6, 8, 18:       return "R6";
      12, 14:         return "R7";
      default:        return "R3";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge; outputs are valid at the next falling edge.
  task automatic doCycle(input logic v, input logic [1:0] op, input logic sel,
                         input logic [39:0] opnd, input logic clr);
    @(negedge clk);
    opValid = v; opCode = op; accSel = sel; operand = opnd; flagClear = clr;
    @(negedge clk);
    opValid = 1'b0; opCode = 2'b11; flagClear = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "accA reset", accA, 40'h0);
    check("R12", "accB reset", accB, 40'h0);
    check("R12", "flags reset", {36'h0, ovfA, ovfB, satA, satB}, 40'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      doCycle(1'b0, 2'b11, 1'b0, 40'h0, 1'b1);
      satEnA = VECS[i].sen; satEnB = VECS[i].sen; satModeExt = VECS[i].ext;
      doCycle(1'b1, VECS[i].op, VECS[i].sel, VECS[i].opnd, 1'b0);
      $display("vector %0d (%s)", i, vecReq(i));
      check(vecReq(i), "acc", VECS[i].sel ? accB : accA, VECS[i].expAcc);
      check(vecReq(i), "ovf", {39'h0, VECS[i].sel ? ovfB : ovfA}, {39'h0, VECS[i].expOvf});
      check(vecReq(i), "sat", {39'h0, VECS[i].sel ? satB : satA}, {39'h0, VECS[i].expSat});
    end

    // R11: A untouched by the operations on B
    check("R11", "accA held", accA, 40'h0100000000);
    check("R11", "ovfA held", {39'h0, ovfA}, 40'h1);
    // R9 summaries: ovfA=1, ovfB=1, satA=0, satB=1
    check("R9", "satA", {39'h0, satA}, 40'h0);
    check("R9", "ovfAny", {39'h0, ovfAny}, 40'h1);
    check("R9", "satAny", {39'h0, satAny}, 40'h1);
    // R10 trap request
    trapEnA = 1'b0; trapEnB = 1'b0; #1;
    check("R10", "trap off", {39'h0, trapReq}, 40'h0);
    trapEnB = 1'b1; #1;
    check("R10", "trap B", {39'h0, trapReq}, 40'h1);

    // R8 sticky flag, R4 recomputed guard flag
    satEnB = 1'b0;
    doCycle(1'b1, 2'b00, 1'b1, 40'h0, 1'b0);
    check("R1", "accB add zero", accB, 40'h007FFFFFFF);
    check("R8", "satB sticky", {39'h0, satB}, 40'h1);
    check("R4", "ovfB recomputed", {39'h0, ovfB}, 40'h0);
    check("R10", "trap after ovf clear", {39'h0, trapReq}, 40'h0);

    // R8 explicit clear
    doCycle(1'b0, 2'b11, 1'b0, 40'h0, 1'b1);
    check("R8", "satB cleared", {39'h0, satB}, 40'h0);
    check("R9", "satAny cleared", {39'h0, satAny}, 40'h0);

    // R8 event wins over clear
    satEnB = 1'b1; satModeExt = 1'b0;
    doCycle(1'b1, 2'b10, 1'b1, 40'h0100000000, 1'b1);
    check("R8", "set beats clear", {39'h0, satB}, 40'h1);
    check("R6", "accB clamp", accB, 40'h007FFFFFFF);

    // R11 idle and no-op code
    doCycle(1'b0, 2'b00, 1'b1, 40'h0000000123, 1'b0);
    check("R11", "idle accB", accB, 40'h007FFFFFFF);
    doCycle(1'b1, 2'b11, 1'b1, 40'h0000000123, 1'b0);
    check("R11", "noop accB", accB, 40'h007FFFFFFF);
    check("R11", "noop ovfB", {39'h0, ovfB}, 40'h1);
    check("R11", "noop accA", accA, 40'h0100000000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule